// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where a 32-bit RISC core fetches from next and whether the current control-flow instruction must save a return address. Each cycle it takes the current program counter, the 6-bit opcode, the short (16-bit) and long (26-bit) offset fields, the value of the register that supplies an indirect target, and the value that a conditional branch tests against zero. One clock later it presents the next program counter, a taken flag, and a link write (enable, register index 31, and data) for the register file.

Every PC-relative target is formed from the sequential address PC+4 plus a sign-extended byte offset, added without shifting. Register-indirect jumps load the program counter straight from the supplied register value. The two linking jumps write PC+4 into register 31, and the register-indirect one still jumps to the value it was given, which is the value before that write. Any opcode that is not one of the six control-flow codes falls through to PC+4.

Top module: `npc_unit`

## Requirements
- R1: While rst_ni is low, next_pc_o is 0, taken_o is 0 and link_we_o is 0.
- R2: Outputs are registered: a change on the inputs appears at the outputs only after the next rising edge of clk_i.
- R3: Opcode 6'b010000 (branch if zero) with test_val_i equal to 0 gives next_pc_o = pc_i + 4 + sign-extended off16_i and taken_o = 1; with test_val_i nonzero it gives pc_i + 4 and taken_o = 0.
- R4: Opcode 6'b010001 (branch if not zero) with test_val_i nonzero gives next_pc_o = pc_i + 4 + sign-extended off16_i and taken_o = 1; with test_val_i equal to 0 it gives pc_i + 4 and taken_o = 0.
- R5: Opcode 6'b001100 (jump) gives next_pc_o = pc_i + 4 + sign-extended off26_i, taken_o = 1 and link_we_o = 0.
- R6: Opcode 6'b001101 (jump and link) gives the same target as R5, taken_o = 1, link_we_o = 1, link_addr_o = 31 and link_data_o = pc_i + 4.
- R7: Opcode 6'b001110 (jump via register) gives next_pc_o = rs_val_i, taken_o = 1 and link_we_o = 0.
- R8: Opcode 6'b001111 (jump via register and link) gives next_pc_o = rs_val_i as presented, taken_o = 1, link_we_o = 1 and link_data_o = pc_i + 4, even when rs_val_i is the old content of register 31.
- R9: Every other opcode gives next_pc_o = pc_i + 4, taken_o = 0 and link_we_o = 0; offsets, rs_val_i and test_val_i have no effect.
- R10: All address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Current program counter |
| opcode_i | input | 6 | Instruction opcode |
| off16_i | input | 16 | Short signed byte offset for branches |
| off26_i | input | 26 | Long signed byte offset for jumps |
| rs_val_i | input | 32 | Register value used as an indirect target |
| test_val_i | input | 32 | Register value a branch compares with zero |
| next_pc_o | output | 32 | Next program counter |
| taken_o | output | 1 | Control flow left the sequential path |
| link_we_o | output | 1 | Write return address to the link register |
| link_addr_o | output | 5 | Link register index (31) |
| link_data_o | output | 32 | Return address PC+4 |

## Verification
The return-address write and the register-indirect jump land in the same cycle for the linking register jump, and the risk is a target that picks up the freshly computed PC+4 instead of the register value it was given. The bench provokes this by issuing that opcode with rs_val_i set to an unrelated old link value and with PC values near the top of the address space, then judges that next_pc_o equals the supplied register value while link_data_o equals the wrapped PC+4 in the same output cycle. The sweep over all 64 opcodes with mixed offsets, test values and PCs confirms that the other five control-flow codes and every non-control code keep their own results.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OP_BRZ   = 6'b010000;
  localparam logic [OPC_W-1:0] OP_BRNZ  = 6'b010001;
  localparam logic [OPC_W-1:0] OP_JMP   = 6'b001100;
  localparam logic [OPC_W-1:0] OP_JMPL  = 6'b001101;
  localparam logic [OPC_W-1:0] OP_JREG  = 6'b001110;
  localparam logic [OPC_W-1:0] OP_JREGL = 6'b001111;

  typedef struct packed {
    logic is_branch;
    logic br_on_nz;
    logic is_jump;
    logic use_reg;
    logic link;
  } npc_ctl_t;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output npc_ctl_t         ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (opcode_i)
      OP_BRZ:   ctl_o.is_branch = 1'b1;
      OP_BRNZ:  begin ctl_o.is_branch = 1'b1; ctl_o.br_on_nz = 1'b1; end
      OP_JMP:   ctl_o.is_jump = 1'b1;
      OP_JMPL:  begin ctl_o.is_jump = 1'b1; ctl_o.link = 1'b1; end
      OP_JREG:  begin ctl_o.is_jump = 1'b1; ctl_o.use_reg = 1'b1; end
      OP_JREGL: begin ctl_o.is_jump = 1'b1; ctl_o.use_reg = 1'b1; ctl_o.link = 1'b1; end
      default:  ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int XLEN  = 32,
  parameter int OFF_S = 16,
  parameter int OFF_L = 26
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_S-1:0] off_s_i,
  input  logic [OFF_L-1:0] off_l_i,
  output logic [XLEN-1:0]  seq_o,
  output logic [XLEN-1:0]  br_tgt_o,
  output logic [XLEN-1:0]  jmp_tgt_o
);
  logic [XLEN-1:0] off_s_ext, off_l_ext;

  // offsets wider than the datapath are truncated, narrower ones sign-extended
  generate
    if (OFF_S < XLEN) begin : g_s_ext
      assign off_s_ext = {{(XLEN-OFF_S){off_s_i[OFF_S-1]}}, off_s_i};
    end else begin : g_s_trunc
      assign off_s_ext = off_s_i[XLEN-1:0];
    end
    if (OFF_L < XLEN) begin : g_l_ext
      assign off_l_ext = {{(XLEN-OFF_L){off_l_i[OFF_L-1]}}, off_l_i};
    end else begin : g_l_trunc
      assign off_l_ext = off_l_i[XLEN-1:0];
    end
  endgenerate

  assign seq_o     = pc_i + XLEN'(4);
  assign br_tgt_o  = seq_o + off_s_ext;
  assign jmp_tgt_o = seq_o + off_l_ext;
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  npc_ctl_t        ctl_i,
  input  logic [XLEN-1:0] test_val_i,
  input  logic [XLEN-1:0] rs_val_i,
  input  logic [XLEN-1:0] seq_i,
  input  logic [XLEN-1:0] br_tgt_i,
  input  logic [XLEN-1:0] jmp_tgt_i,
  output logic [XLEN-1:0] next_o,
  output logic            taken_o,
  output logic            link_o
);
  logic is_zero, cond;

  assign is_zero = (test_val_i == '0);
  assign cond    = ctl_i.br_on_nz ? !is_zero : is_zero;

  always_comb begin
    next_o  = seq_i;
    taken_o = 1'b0;
    link_o  = 1'b0;
    if (ctl_i.is_branch) begin
      if (cond) begin
        next_o  = br_tgt_i;
        taken_o = 1'b1;
      end
    end else if (ctl_i.is_jump) begin
      // register target is the value presented, never the link data
      next_o  = ctl_i.use_reg ? rs_val_i : jmp_tgt_i;
      taken_o = 1'b1;
      link_o  = ctl_i.link;
    end
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_S = 16,
  parameter int OFF_L = 26,
  parameter int NREGS = 32,
  localparam int RIDX_W = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [OFF_S-1:0]  off16_i,
  input  logic [OFF_L-1:0]  off26_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   test_val_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              taken_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_addr_o,
  output logic [XLEN-1:0]   link_data_o
);
  npc_ctl_t        ctl;
  logic [XLEN-1:0] seq, br_tgt, jmp_tgt, next_d;
  logic            taken_d, link_d;

  npc_decode u_dec (
    .opcode_i (opcode_i),
    .ctl_o    (ctl)
  );

  npc_target #(.XLEN(XLEN), .OFF_S(OFF_S), .OFF_L(OFF_L)) u_tgt (
    .pc_i      (pc_i),
    .off_s_i   (off16_i),
    .off_l_i   (off26_i),
    .seq_o     (seq),
    .br_tgt_o  (br_tgt),
    .jmp_tgt_o (jmp_tgt)
  );

  npc_select #(.XLEN(XLEN)) u_sel (
    .ctl_i      (ctl),
    .test_val_i (test_val_i),
    .rs_val_i   (rs_val_i),
    .seq_i      (seq),
    .br_tgt_i   (br_tgt),
    .jmp_tgt_i  (jmp_tgt),
    .next_o     (next_d),
    .taken_o    (taken_d),
    .link_o     (link_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o   <= '0;
      taken_o     <= 1'b0;
      link_we_o   <= 1'b0;
      link_data_o <= '0;
    end else begin
      next_pc_o   <= next_d;
      taken_o     <= taken_d;
      link_we_o   <= link_d;
      link_data_o <= seq;
    end
  end

  assign link_addr_o = RIDX_W'(NREGS - 1);
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [XLEN-1:0]  pc_i,
  input logic [OPC_W-1:0] opcode_i,
  input logic [XLEN-1:0]  rs_val_i,
  input logic [XLEN-1:0]  test_val_i,
  input logic [XLEN-1:0]  next_pc_o,
  input logic             taken_o,
  input logic             link_we_o,
  input logic [XLEN-1:0]  link_data_o
);
  logic is_ctl, is_link;
  assign is_ctl  = (opcode_i == OP_BRZ) || (opcode_i == OP_BRNZ) || (opcode_i == OP_JMP) ||
                   (opcode_i == OP_JMPL) || (opcode_i == OP_JREG) || (opcode_i == OP_JREGL);
  assign is_link = (opcode_i == OP_JMPL) || (opcode_i == OP_JREGL);

  assert_brz_taken_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == OP_BRZ && test_val_i == '0) |=> taken_o);

  assert_brnz_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == OP_BRNZ && test_val_i == '0) |=>
      (!taken_o && next_pc_o == $past(pc_i) + XLEN'(4)));

  assert_jmpl_link_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_link |=> (link_we_o && link_data_o == $past(pc_i) + XLEN'(4)));

  assert_jreg_tgt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == OP_JREG) |=> (taken_o && !link_we_o && next_pc_o == $past(rs_val_i)));

  assert_jregl_tgt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == OP_JREGL) |=> (taken_o && next_pc_o == $past(rs_val_i)));

  assert_seq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_ctl |=> (!taken_o && next_pc_o == $past(pc_i) + XLEN'(4)));

  assert_no_link_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_link |=> !link_we_o);
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pc_i        (pc_i),
  .opcode_i    (opcode_i),
  .rs_val_i    (rs_val_i),
  .test_val_i  (test_val_i),
  .next_pc_o   (next_pc_o),
  .taken_o     (taken_o),
  .link_we_o   (link_we_o),
  .link_data_o (link_data_o)
);

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc_i = '0;
  logic [5:0]  opcode_i = '0;
  logic [15:0] off16_i = '0;
  logic [25:0] off26_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [31:0] test_val_i = '0;
  logic [31:0] next_pc_o;
  logic        taken_o;
  logic        link_we_o;
  logic [4:0]  link_addr_o;
  logic [31:0] link_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  npc_unit dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pc_i        (pc_i),
    .opcode_i    (opcode_i),
    .off16_i     (off16_i),
    .off26_i     (off26_i),
    .rs_val_i    (rs_val_i),
    .test_val_i  (test_val_i),
    .next_pc_o   (next_pc_o),
    .taken_o     (taken_o),
    .link_we_o   (link_we_o),
    .link_addr_o (link_addr_o),
    .link_data_o (link_data_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  logic [31:0] e_next, e_ld;
  logic        e_taken, e_we;
  string       e_req;

  task automatic model();
    logic [31:0] seq;
    seq     = pc_i + 32'd4;
    e_ld    = seq;
    e_next  = seq;
    e_taken = 1'b0;
    e_we    = 1'b0;
    e_req   = "R9";
    case (opcode_i)
      6'b010000: begin e_req = "R3";
        if (test_val_i == 0) begin e_next = seq + {{16{off16_i[15]}}, off16_i}; e_taken = 1'b1; end end
      6'b010001: begin e_req = "R4";
        if (test_val_i != 0) begin e_next = seq + {{16{off16_i[15]}}, off16_i}; e_taken = 1'b1; end end
      6'b001100: begin e_req = "R5"; e_next = seq + {{6{off26_i[25]}}, off26_i}; e_taken = 1'b1; end
      6'b001101: begin e_req = "R6"; e_next = seq + {{6{off26_i[25]}}, off26_i}; e_taken = 1'b1; e_we = 1'b1; end
      6'b001110: begin e_req = "R7"; e_next = rs_val_i; e_taken = 1'b1; end
      6'b001111: begin e_req = "R8"; e_next = rs_val_i; e_taken = 1'b1; e_we = 1'b1; end
      default: ;
    endcase
  endtask

  task automatic check_out();
    chk(e_req, "next_pc", next_pc_o, e_next);
    chk(e_req, "taken", {31'b0, taken_o}, {31'b0, e_taken});
    chk(e_req, "link_we", {31'b0, link_we_o}, {31'b0, e_we});
    if (e_we) begin
      chk(e_req, "link_data", link_data_o, e_ld);
      chk(e_req, "link_addr", {27'b0, link_addr_o}, 32'd31);
    end
  endtask

  // drive at negedge, outputs settle after following posedge, sample at next negedge
  task automatic apply(input logic [5:0] op, input logic [31:0] pc, input logic [15:0] o16,
                       input logic [25:0] o26, input logic [31:0] rs, input logic [31:0] tv);
    @(negedge clk_i);
    opcode_i = op; pc_i = pc; off16_i = o16; off26_i = o26; rs_val_i = rs; test_val_i = tv;
    model();
    @(negedge clk_i);
    check_out();
  endtask

  initial begin
    logic [31:0] prev_next;
    repeat (3) @(negedge clk_i);
    chk("R1", "next_pc in reset", next_pc_o, 32'd0);
    chk("R1", "taken in reset", {31'b0, taken_o}, 32'd0);
    chk("R1", "link_we in reset", {31'b0, link_we_o}, 32'd0);
    rst_ni = 1'b1;

    // sweep every opcode against mixed operand patterns
    for (int op = 0; op < 64; op++) begin
      for (int k = 0; k < 8; k++) begin
        logic [31:0] pc, rs, tv;
        logic [15:0] o16;
        logic [25:0] o26;
        pc  = (k == 7) ? 32'hFFFF_FFFC : (32'h1000_0000 * k + 32'(op) * 4);
        case (k % 4)
          0: o16 = 16'h0000;
          1: o16 = 16'h0010;
          2: o16 = 16'hFFF0;
          default: o16 = 16'h8000;
        endcase
        case (k % 4)
          0: o26 = 26'h2000000;
          1: o26 = 26'h3FFFFF0;
          2: o26 = 26'h0000400;
          default: o26 = 26'h1FFFFFC;
        endcase
        rs = 32'hA5A5_0000 + 32'(k);
        tv = k[0] ? 32'h0 : ((k == 4) ? 32'h8000_0000 : 32'(k + 1));
        apply(6'(op), pc, o16, o26, rs, tv);
      end
    end

    // R8: register target equals old link content while link data is new PC+4, wrapping
    apply(6'b001111, 32'hFFFF_FFFC, 16'h1234, 26'h0, 32'h0000_4000, 32'h0);
    chk("R8", "jalr uses presented reg, not link", next_pc_o, 32'h0000_4000);
    chk("R8", "jalr link data wraps", link_data_o, 32'h0000_0000);
    apply(6'b001111, 32'h0000_1000, 16'h0, 26'h0, 32'h0000_1004, 32'h0);
    // R10: branch and jump wrap around address space
    apply(6'b010000, 32'hFFFF_FFF8, 16'h0010, 26'h0, 32'h0, 32'h0);
    chk("R10", "branch wrap", next_pc_o, 32'h0000_000C);
    apply(6'b001100, 32'h0000_0000, 16'h0, 26'h3FFFFF8, 32'h0, 32'h0);
    chk("R10", "jump wrap backward", next_pc_o, 32'hFFFF_FFFC);

    // R2: new inputs do not reach outputs before the next rising edge
    @(negedge clk_i);
    prev_next = next_pc_o;
    opcode_i = 6'b001110; rs_val_i = 32'hDEAD_BEE0;
    #1;
    chk("R2", "output held before edge", next_pc_o, prev_next);
    @(negedge clk_i);
    chk("R2", "output after edge", next_pc_o, 32'hDEAD_BEE0);

    // R1: asynchronous reset mid-run
    @(negedge clk_i);
    opcode_i = 6'b001101;
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #1;
    chk("R1", "async reset next_pc", next_pc_o, 32'd0);
    chk("R1", "async reset link_we", {31'b0, link_we_o}, 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk_i); errors++; checks++; $display("FAIL watchdog: actual=timeout expected=done"); end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule